// File: doc/BRIEF.md
# Multi-mode host bus front end

This block sits between a microprocessor and the rest of a display controller. It accepts bytes from the host over one of three bus styles. Two styles are parallel: one uses separate read and write strobes that are active low, and the other uses an enable strobe plus a read/write direction line. The third style is a clocked serial link that reuses two of the data pins. Two strap inputs pick the style, and the block samples them only while reset is held. After reset the choice stays fixed until the next reset.

Every host pin passes through a two-stage synchronizer into the internal clock domain. Strobe edges are detected after that synchronizer. Each completed write leaves the block as an 8-bit byte with a flag that marks it as display data or as a command. The flag comes from the host address line, and the byte is qualified by a valid pulse that lasts one clock. In the parallel styles the block also returns read data from the core. It asserts the output enable only while a qualified read cycle is in progress. A transfer counts only when the active-low chip select is low and the active-high chip select is high.

Top module: `host_bus_frontend`

## Requirements
- R1: While reset is held and in the first cycles after it is released, `rx_valid` and `host_d_oe` are both low.
- R2: The block samples `sel_parallel` (1 = parallel, 0 = serial) and `sel_m68` (1 = enable/direction style, 0 = separate-strobe style) only while `rst_n` is low. Changing these pins after reset has no effect on how the block decodes transfers.
- R3: Unless `csel_n` is 0 and `csel` is 1, writes produce no byte and `host_d_oe` stays low.
- R4: In separate-strobe mode, a rising edge on `strb_wr_rw` (the write strobe, active low) delivers `host_d_in` as the byte.
- R5: In separate-strobe mode, `host_d_oe` is high while `strb_rd_e` (the read strobe) is low, and `host_d_out` then equals `core_rd_data`.
- R6: In enable/direction mode, a falling edge of `strb_rd_e` (the enable, active high) while `strb_wr_rw` is 0 (write) delivers `host_d_in` as the byte.
- R7: In enable/direction mode, `host_d_oe` is high while the enable is high and `strb_wr_rw` is 1 (read). A falling edge of the enable during a read produces no byte.
- R8: In serial mode, bit 6 of `host_d_in` is the serial clock and bit 7 is the serial data. The block samples the data on each rising clock edge, most significant bit first. The eighth bit completes the byte, and bits 5..0 are ignored.
- R9: In serial mode, deselecting the chip clears the bit count, so bits received before the deselect are discarded.
- R10: In serial mode, `host_d_oe` is never asserted.
- R11: Each completed write gives exactly one `rx_valid` pulse, one clock long. The pulse appears on the third rising clock edge after the strobe edge that completes the write.
- R12: `rx_is_data` copies the address line that goes with the write: 1 means display data and 0 means command. In serial mode the address line is sampled together with the eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_parallel | input | 1 | Bus style strap: 1 = parallel, 0 = serial |
| sel_m68 | input | 1 | Parallel style strap: 1 = enable/direction, 0 = separate strobes |
| csel_n | input | 1 | Chip select, active low |
| csel | input | 1 | Chip select, active high |
| strb_rd_e | input | 1 | Read strobe (active low) or enable (active high) |
| strb_wr_rw | input | 1 | Write strobe (active low) or direction (1 = read) |
| addr_dc | input | 1 | Byte type: 1 = display data, 0 = command |
| host_d_in | input | 8 | Host data bus in; in serial mode bit 6 is the clock and bit 7 the data |
| core_rd_data | input | 8 | Read data supplied by the core |
| host_d_out | output | 8 | Data driven back to the host |
| host_d_oe | output | 1 | Output enable for the host data bus |
| rx_valid | output | 1 | One-cycle pulse marking a received byte |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | Received byte is display data (1) or command (0) |

## Verification
In separate-strobe mode a read and a write can be active in the same cycle. The bench holds the read strobe low, then pulses the write strobe while the read is still open. It expects the output enable to stay high with the read data on the bus, and it expects the written byte to reach the scoreboard as well. The serial bit counter is also tested against a deselect. The bench sends a partial byte, then deselects, then sends a full byte. If stale bits were merged into the full byte, the byte would come out early or with the wrong value, and the scoreboard comparison would report it.

// File: rtl/hbf_pkg.sv
package hbf_pkg;

    localparam int BYTE_W  = 8;
    localparam int SCL_BIT = 6;
    localparam int SDI_BIT = 7;
    localparam int CNT_W   = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        BUS_SER = 2'd0,
        BUS_I80 = 2'd1,
        BUS_M68 = 2'd2
    } bus_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              is_data;
    } host_byte_t;

    typedef struct packed {
        logic              cs_n;
        logic              cs;
        logic              strb;
        logic              dir;
        logic              dc;
        logic [BYTE_W-1:0] bus;
    } host_pins_t;

    function automatic bus_mode_e pick_mode(input logic par, input logic m68);
        if (!par)     return BUS_SER;
        else if (m68) return BUS_M68;
        else          return BUS_I80;
    endfunction

    function automatic logic cs_qualified(input host_pins_t p);
        return !p.cs_n && p.cs;
    endfunction

endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    // Free-running so that edge memories downstream track the pins through reset
    always_ff @(posedge clk) begin
        chain[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hbf_par_decode.sv
module hbf_par_decode
    import hbf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              m68,
    input  logic              cs_ok,
    input  logic              strb,
    input  logic              dir,
    input  logic              dc,
    input  logic [BYTE_W-1:0] bus,
    output logic              wr_fire,
    output host_byte_t        wr_byte,
    output logic              rd_active
);

    logic strb_q;
    logic dir_q;

    always_ff @(posedge clk) begin
        strb_q <= strb;
        dir_q  <= dir;
    end

    logic i80_wr_rise;
    logic m68_e_fall;

    // separate-strobe: write strobe returns high; enable style: enable drops in write direction
    assign i80_wr_rise = dir && !dir_q;
    assign m68_e_fall  = strb_q && !strb && !dir;

    always_comb begin
        wr_fire   = 1'b0;
        rd_active = 1'b0;
        if (en && cs_ok) begin
            if (m68) begin
                wr_fire   = m68_e_fall;
                rd_active = strb && dir;
            end else begin
                wr_fire   = i80_wr_rise;
                rd_active = !strb;
            end
        end
    end

    assign wr_byte.data    = bus;
    assign wr_byte.is_data = dc;

    AST_PAR_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire) else $error("parallel write fired twice in a row"); // R11

endmodule

// File: rtl/hbf_ser_shift.sv
module hbf_ser_shift
    import hbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cs_ok,
    input  logic       scl,
    input  logic       sdi,
    input  logic       dc,
    output logic       done,
    output host_byte_t rx
);

    logic              scl_q;
    logic              scl_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    always_ff @(posedge clk) begin
        scl_q <= scl;
    end

    assign scl_rise = scl && !scl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (!en || !cs_ok) begin
            bit_cnt <= '0;
        end else if (scl_rise) begin
            shreg   <= {shreg[BYTE_W-2:0], sdi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign done       = en && cs_ok && scl_rise && (bit_cnt == CNT_W'(BYTE_W-1));
    assign rx.data    = {shreg[BYTE_W-2:0], sdi};
    assign rx.is_data = dc;

    AST_SER_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_ok |=> (bit_cnt == '0)) else $error("serial bit count survived deselect"); // R9

endmodule

// File: rtl/host_bus_frontend.sv
module host_bus_frontend
    import hbf_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_parallel,
    input  logic              sel_m68,
    input  logic              csel_n,
    input  logic              csel,
    input  logic              strb_rd_e,
    input  logic              strb_wr_rw,
    input  logic              addr_dc,
    input  logic [BYTE_W-1:0] host_d_in,
    input  logic [BYTE_W-1:0] core_rd_data,
    output logic [BYTE_W-1:0] host_d_out,
    output logic              host_d_oe,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data
);

    localparam int PINS_W = $bits(host_pins_t);

    // straps captured only during reset
    logic cfg_par;
    logic cfg_m68;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_par <= sel_parallel;
            cfg_m68 <= sel_m68;
        end
    end

    bus_mode_e mode;
    assign mode = pick_mode(cfg_par, cfg_m68);

    host_pins_t pins_raw;
    host_pins_t pins_s;

    assign pins_raw.cs_n = csel_n;
    assign pins_raw.cs   = csel;
    assign pins_raw.strb = strb_rd_e;
    assign pins_raw.dir  = strb_wr_rw;
    assign pins_raw.dc   = addr_dc;
    assign pins_raw.bus  = host_d_in;

    hbf_sync #(.W(PINS_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   (pins_raw),
        .q   (pins_s)
    );

    logic cs_ok;
    assign cs_ok = cs_qualified(pins_s);

    logic       par_fire;
    logic       par_rd;
    host_byte_t par_byte;

    hbf_par_decode u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mode != BUS_SER),
        .m68       (mode == BUS_M68),
        .cs_ok     (cs_ok),
        .strb      (pins_s.strb),
        .dir       (pins_s.dir),
        .dc        (pins_s.dc),
        .bus       (pins_s.bus),
        .wr_fire   (par_fire),
        .wr_byte   (par_byte),
        .rd_active (par_rd)
    );

    logic       ser_done;
    host_byte_t ser_byte;

    hbf_ser_shift u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mode == BUS_SER),
        .cs_ok (cs_ok),
        .scl   (pins_s.bus[SCL_BIT]),
        .sdi   (pins_s.bus[SDI_BIT]),
        .dc    (pins_s.dc),
        .done  (ser_done),
        .rx    (ser_byte)
    );

    host_byte_t out_q;
    logic       valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= par_fire || ser_done;
            if (ser_done)      out_q <= ser_byte;
            else if (par_fire) out_q <= par_byte;
        end
    end

    assign rx_valid   = valid_q;
    assign rx_byte    = out_q.data;
    assign rx_is_data = out_q.is_data;

    assign host_d_oe  = rst_n && par_rd;
    assign host_d_out = host_d_oe ? core_rd_data : '0;

    AST_OE_NEVER_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_par |-> !host_d_oe) else $error("bus driven in serial mode"); // R10

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        host_d_oe |-> $past(!csel_n && csel, 2)) else $error("bus driven while deselected"); // R3

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid) else $error("valid longer than a cycle"); // R11

    AST_STRAPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_par) && $stable(cfg_m68)) else $error("straps changed while running"); // R2

endmodule

// File: tb/host_bus_frontend_tb_top.sv
`timescale 1ns/1ps
module host_bus_frontend_tb_top;
    import hbf_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_parallel = 1'b1;
    logic       sel_m68 = 1'b0;
    logic       csel_n = 1'b1;
    logic       csel = 1'b0;
    logic       strb_rd_e = 1'b1;
    logic       strb_wr_rw = 1'b1;
    logic       addr_dc = 1'b0;
    logic [7:0] host_d_in = 8'h00;
    logic [7:0] core_rd_data = 8'h00;
    logic [7:0] host_d_out;
    logic       host_d_oe;
    logic       rx_valid;
    logic [7:0] rx_byte;
    logic       rx_is_data;

    always #2.5 clk = ~clk;

    host_bus_frontend dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_parallel (sel_parallel),
        .sel_m68      (sel_m68),
        .csel_n       (csel_n),
        .csel         (csel),
        .strb_rd_e    (strb_rd_e),
        .strb_wr_rw   (strb_wr_rw),
        .addr_dc      (addr_dc),
        .host_d_in    (host_d_in),
        .core_rd_data (core_rd_data),
        .host_d_out   (host_d_out),
        .host_d_oe    (host_d_oe),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_is_data   (rx_is_data)
    );

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         finished = 1'b0;
    host_byte_t exp_q[$];
    string      tag_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_byte(input logic [7:0] d, input logic dcv, input string tag);
        host_byte_t e;
        e.data    = d;
        e.is_data = dcv;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected byte", {23'd0, rx_byte, rx_is_data}, 32'd0);
            end else begin
                host_byte_t e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_byte == e.data && rx_is_data == e.is_data, t, "byte/flag",
                      {23'd0, rx_byte, rx_is_data}, {23'd0, e.data, e.is_data});
            end
        end
    end

    task automatic oe_check(input logic exp_oe, input logic [7:0] exp_d, input string req);
        @(negedge clk);
        check(host_d_oe == exp_oe, req, "output enable", {31'd0, host_d_oe}, {31'd0, exp_oe});
        if (exp_oe)
            check(host_d_out == exp_d, req, "read data", {24'd0, host_d_out}, {24'd0, exp_d});
        step(1);
    endtask

    task automatic do_reset(input logic par, input logic m68);
        rst_n        = 1'b0;
        sel_parallel = par;
        sel_m68      = m68;
        csel_n       = 1'b1;
        csel         = 1'b0;
        strb_rd_e    = m68 ? 1'b0 : 1'b1;
        strb_wr_rw   = 1'b1;
        host_d_in    = 8'h00;
        step(6);
        @(negedge clk);
        check(rx_valid == 1'b0 && host_d_oe == 1'b0, "R1", "outputs in reset",
              {30'd0, rx_valid, host_d_oe}, 32'd0);
        step(1);
        rst_n = 1'b1;
        step(2);
        @(negedge clk);
        check(rx_valid == 1'b0 && host_d_oe == 1'b0, "R1", "outputs after reset",
              {30'd0, rx_valid, host_d_oe}, 32'd0);
        step(1);
    endtask

    task automatic set_cs(input logic n_v, input logic p_v);
        csel_n = n_v;
        csel   = p_v;
        step(3);
    endtask

    task automatic i80_write(input logic [7:0] d, input logic dcv);
        host_d_in  = d;
        addr_dc    = dcv;
        step(2);
        strb_wr_rw = 1'b0;
        step(3);
        strb_wr_rw = 1'b1;
        step(4);
    endtask

    task automatic i80_read(input logic [7:0] v, input logic exp_oe, input string req);
        core_rd_data = v;
        strb_rd_e    = 1'b0;
        step(4);
        oe_check(exp_oe, v, req);
        strb_rd_e    = 1'b1;
        step(4);
        oe_check(1'b0, v, req);
    endtask

    task automatic m68_write(input logic [7:0] d, input logic dcv);
        host_d_in  = d;
        addr_dc    = dcv;
        strb_wr_rw = 1'b0;
        step(2);
        strb_rd_e  = 1'b1;
        step(3);
        strb_rd_e  = 1'b0;
        step(3);
        strb_wr_rw = 1'b1;
        step(3);
    endtask

    task automatic m68_read(input logic [7:0] v, input logic exp_oe, input string req);
        core_rd_data = v;
        strb_wr_rw   = 1'b1;
        step(2);
        strb_rd_e    = 1'b1;
        step(4);
        oe_check(exp_oe, v, req);
        strb_rd_e    = 1'b0;
        step(4);
        oe_check(1'b0, v, req);
    endtask

    task automatic ser_bits(input logic [7:0] d, input int nbits, input logic dcv);
        for (int i = 0; i < nbits; i++) begin
            host_d_in[SDI_BIT] = d[7-i];
            host_d_in[SCL_BIT] = 1'b0;
            if (i == 7) addr_dc = dcv;
            step(3);
            host_d_in[SCL_BIT] = 1'b1;
            step(3);
        end
        host_d_in[SCL_BIT] = 1'b0;
        step(4);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // separate-strobe parallel
        do_reset(1'b1, 1'b0);
        set_cs(1'b0, 1'b1);
        expect_byte(8'h3C, 1'b1, "R4");  i80_write(8'h3C, 1'b1);
        expect_byte(8'h81, 1'b0, "R12"); i80_write(8'h81, 1'b0);
        expect_byte(8'hFF, 1'b1, "R4");  i80_write(8'hFF, 1'b1);
        i80_read(8'h5A, 1'b1, "R5");

        // read held open while a write completes
        core_rd_data = 8'hC7;
        strb_rd_e    = 1'b0;
        step(4);
        expect_byte(8'h96, 1'b1, "R4");
        host_d_in    = 8'h96;
        addr_dc      = 1'b1;
        step(2);
        strb_wr_rw   = 1'b0;
        step(3);
        strb_wr_rw   = 1'b1;
        step(2);
        oe_check(1'b1, 8'hC7, "R5");
        step(2);
        strb_rd_e    = 1'b1;
        step(4);

        // straps changed after reset: still separate-strobe parallel
        sel_parallel = 1'b0;
        sel_m68      = 1'b1;
        step(3);
        expect_byte(8'h42, 1'b0, "R2"); i80_write(8'h42, 1'b0);
        i80_read(8'h19, 1'b1, "R2");
        sel_parallel = 1'b1;
        sel_m68      = 1'b0;

        // chip select qualification
        set_cs(1'b1, 1'b0);
        i80_write(8'h11, 1'b1);
        i80_read(8'h22, 1'b0, "R3");
        set_cs(1'b0, 1'b0);
        i80_write(8'h33, 1'b0);
        set_cs(1'b1, 1'b1);
        i80_read(8'h44, 1'b0, "R3");
        i80_write(8'h55, 1'b1);
        step(6);
        check(exp_q.size() == 0, "R3", "pending after deselected writes",
              exp_q.size(), 32'd0);

        // enable/direction parallel
        do_reset(1'b1, 1'b1);
        set_cs(1'b0, 1'b1);
        expect_byte(8'hA7, 1'b1, "R6");  m68_write(8'hA7, 1'b1);
        expect_byte(8'h10, 1'b0, "R12"); m68_write(8'h10, 1'b0);
        m68_read(8'hC3, 1'b1, "R7");
        m68_read(8'h3E, 1'b1, "R7");
        set_cs(1'b1, 1'b0);
        m68_write(8'h77, 1'b1);
        m68_read(8'h66, 1'b0, "R3");
        set_cs(1'b0, 1'b1);
        step(6);
        check(exp_q.size() == 0, "R7", "pending after enable-style reads",
              exp_q.size(), 32'd0);

        // serial
        do_reset(1'b0, 1'b0);
        set_cs(1'b0, 1'b1);
        host_d_in[5:0] = 6'h2A;
        expect_byte(8'hB4, 1'b1, "R8");  ser_bits(8'hB4, 8, 1'b1);
        host_d_in[5:0] = 6'h15;
        expect_byte(8'h0F, 1'b0, "R12"); ser_bits(8'h0F, 8, 1'b0);
        strb_rd_e  = 1'b0;
        strb_wr_rw = 1'b1;
        step(4);
        oe_check(1'b0, 8'h00, "R10");
        strb_rd_e  = 1'b1;
        ser_bits(8'hE0, 3, 1'b0);
        set_cs(1'b1, 1'b0);
        step(2);
        set_cs(1'b0, 1'b1);
        expect_byte(8'h6D, 1'b1, "R9");  ser_bits(8'h6D, 8, 1'b1);
        oe_check(1'b0, 8'h00, "R10");

        step(10);
        check(exp_q.size() == 0, "R11", "bytes never delivered", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule